// File: doc/BRIEF.md
# Byte-wide serial port with receive queue

This block is a UART peripheral for an 8-bit host bus. Its programming model is that of a classic asynchronous communications adapter. The host reaches two register locations through a single select bit. Location 0 holds status on reads and control on writes. Location 1 is the data port, used to send a byte or to take a received byte. Reads and writes use active-low strobes. An access happens once per strobe assertion, in the first clock cycle in which the strobe is seen low. Transmit and receive timing both advance only on cycles where `clk_en16` is high. That enable is supplied from outside and pulses at sixteen times the bit rate.

Frames are 8 data bits, no parity and one stop bit, sent LSB first, with the line idling high. Received bytes are queued in a FIFO. The RTS output warns the far end when the queue is close to full. The transmitter starts a new frame only while the far end holds CTS low.

Internally the data path is streamed with valid/ready. The one-byte transmit holding register offers its byte to the serializer. The serializer takes the byte only when it is idle and CTS is low. That is the only back-pressure on the transmit side; a host write made while the holding register is occupied is dropped. The receive side has no back-pressure toward the line. A byte that arrives while the FIFO is full is lost, and RTS is the means of avoiding that.

Top module: `acia_uart`

## Requirements
- R1: After reset the status reads 0x02, `txd` is high, `rts_n` is low, and no received byte is pending.
- R2: A status read (select 0) returns bit0 = receive-full and bit1 = transmit-empty. Bits 2, 3 and 6:4 read 0, so carrier and clear-to-send always appear present. Bit7 = interrupt pending. A write to select 0 loads control; select 1 is the data port. Each strobe assertion performs exactly one access.
- R3: A data write accepted while transmit-empty is 1 clears transmit-empty. The byte is sent as one low start bit, 8 data bits LSB first and one high stop bit, each lasting 16 enables. Transmit-empty returns to 1 when the frame starts.
- R4: A data write made while transmit-empty is 0 is ignored; the held byte is kept and the new byte is never sent.
- R5: A held byte starts its frame only while `cts_n` is low. While `cts_n` is high, `txd` stays high and transmit-empty stays 0.
- R6: A received start bit must still be low 8 enables after the falling edge, or it is discarded. Data bits are then sampled every 16 enables. A frame whose stop bit samples low is discarded.
- R7: Received bytes enter a 16-entry FIFO in arrival order. Receive-full is 1 while the FIFO is non-empty. Each data read removes one byte, and a data read of an empty FIFO changes nothing. A byte arriving while 16 are held is dropped.
- R8: `rts_n` is high when control bits 6:5 = 10 or when the FIFO holds 14 or more bytes, and low otherwise.
- R9: Status bit7 = (receive-full AND control bit7) OR (transmit-empty AND control bits 6:5 = 01).
- R10: A control write with bits 1:0 = 11 empties the FIFO, drops the held byte, aborts any frame in progress (`txd` high at once) and returns the receiver to idle; control bits 7:5 are loaded from the same write.
- R11: While `clk_en16` stays low, neither the transmit nor the receive timing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 = status/control, 1 = data |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host (status or FIFO head) |
| clk_en16 | input | 1 | Enable pulse at 16x bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Active-low request to send |
| cts_n | input | 1 | Active-low clear to send |

## Verification
Embedded properties check several things on every cycle:
- the serializer begins a frame only after CTS was seen low;
- an accepted data write empties transmit-empty in the next cycle;
- a rejected write leaves the held byte untouched;
- master reset leaves transmit-empty set, receive-full clear and the serializer idle;
- the FIFO count moves by exactly one per push or pop and never exceeds its depth.

Serial timing can only be shown by the bench's scenarios, because it covers whole frames: the LSB-first order, the start-bit glitch rejection, the discard on a bad stop bit, and the behaviour when the enable stops. The same holds for the RTS threshold, the dropped 17th byte and the interrupt combinations.

// File: rtl/acia_pkg.sv
package acia_pkg;
  localparam int REG_W = 8;

  // status bit positions (host software decodes these)
  localparam int ST_RXFULL  = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_IRQ     = 7;

  // transmitter-control field encodings
  localparam logic [1:0] TXC_QUIET  = 2'b00;
  localparam logic [1:0] TXC_IRQ_ON = 2'b01;
  localparam logic [1:0] TXC_HOLD   = 2'b10;
  localparam logic [1:0] TXC_OTHER  = 2'b11;

  localparam logic [1:0] CMD_MRESET = 2'b11;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/acia_fifo.sv
module acia_fifo #(
  parameter int W           = 8,
  parameter int DEPTH       = 16,
  parameter int AFULL_LEVEL = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         afull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_AF  = CNT_W'(AFULL_LEVEL);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign afull   = (count >= CNT_AF);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PTR_END) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_END) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r7_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |=> !empty);
  a_r7_pop_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty && !clr) |=> (count == $past(count) - 1'b1));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
endmodule

// File: rtl/acia_tx.sv
module acia_tx #(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         txd
);
  localparam int TICK_W = $clog2(OVS);
  localparam int BIT_W  = $clog2(W + 2);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(W + 1);

  logic              busy;
  logic [W:0]        shreg;   // {stop, data}
  logic [TICK_W-1:0] tick;
  logic [BIT_W-1:0]  nbit;
  logic              line_q;

  assign in_ready = !busy;
  assign txd      = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      shreg  <= '1;
      tick   <= '0;
      nbit   <= '0;
      line_q <= 1'b1;
    end else if (clr) begin
      busy   <= 1'b0;
      shreg  <= '1;
      tick   <= '0;
      nbit   <= '0;
      line_q <= 1'b1;
    end else if (!busy) begin
      if (in_valid) begin
        busy   <= 1'b1;
        shreg  <= {1'b1, in_data};
        tick   <= '0;
        nbit   <= '0;
        line_q <= 1'b0;          // start bit
      end
    end else if (tick_en) begin
      if (tick == TICK_LAST) begin
        tick <= '0;
        if (nbit == BIT_LAST) begin
          busy   <= 1'b0;
          line_q <= 1'b1;
        end else begin
          line_q <= shreg[0];
          shreg  <= {1'b1, shreg[W:1]};
          nbit   <= nbit + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  a_r3_frame_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> txd);
  a_r11_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en && !clr) |=> ($stable(txd) && $stable(tick)));
endmodule

// File: rtl/acia_rx.sv
module acia_rx
  import acia_pkg::*;
#(
  parameter int W   = 8,
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_en,
  input  logic         rxd,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int TICK_W = $clog2(OVS);
  localparam int BIT_W  = $clog2(W);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVS - 1);
  localparam logic [TICK_W-1:0] TICK_MID  = TICK_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(W - 1);

  rx_state_t         state;
  logic [1:0]        sync;
  logic              line;
  logic [TICK_W-1:0] tick;
  logic [BIT_W-1:0]  nbit;
  logic [W-1:0]      shreg;
  logic              valid_q;

  assign line      = sync[1];
  assign out_valid = valid_q;
  assign out_data  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      tick    <= '0;
      nbit    <= '0;
      shreg   <= '0;
      valid_q <= 1'b0;
    end else if (clr) begin
      state   <= RX_IDLE;
      tick    <= '0;
      nbit    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick_en) begin
        case (state)
          RX_IDLE: begin
            tick <= '0;
            if (!line) state <= RX_START;
          end
          RX_START: begin
            if (tick == TICK_MID) begin
              tick  <= '0;
              nbit  <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          RX_DATA: begin
            if (tick == TICK_LAST) begin
              tick  <= '0;
              shreg <= {line, shreg[W-1:1]};
              if (nbit == BIT_LAST) state <= RX_STOP;
              else                  nbit  <= nbit + 1'b1;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          RX_STOP: begin
            if (tick == TICK_LAST) begin
              tick    <= '0;
              valid_q <= line;
              state   <= RX_IDLE;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  a_r6_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && tick_en && tick == TICK_MID && line && !clr)
      |=> (state == RX_IDLE));
  a_r6_single_push: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r6_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state) == RX_STOP));
endmodule

// File: rtl/acia_uart.sv
module acia_uart
  import acia_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int AFULL_LEVEL = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] dout,
  input  logic             clk_en16,
  input  logic             rxd,
  output logic             txd,
  output logic             rts_n,
  input  logic             cts_n
);
  // host strobe edge detection: one access per assertion
  logic wr_q, rd_q, wr_stb, rd_stb;
  logic ctrl_wr, data_wr, data_rd, mreset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_stb  = !wr_n && wr_q;
  assign rd_stb  = !rd_n && rd_q;
  assign ctrl_wr = wr_stb && !reg_sel;
  assign data_wr = wr_stb && reg_sel;
  assign data_rd = rd_stb && reg_sel;
  assign mreset  = ctrl_wr && (din[1:0] == CMD_MRESET);

  // control field
  logic       rx_ie;
  logic [1:0] txc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ie <= 1'b0;
      txc   <= TXC_QUIET;
    end else if (ctrl_wr) begin
      rx_ie <= din[7];
      txc   <= din[6:5];
    end
  end

  // CTS synchronizer
  logic [1:0] cts_sync;
  logic       cts_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_sync <= 2'b11;
    else        cts_sync <= {cts_sync[0], cts_n};
  end
  assign cts_s = cts_sync[1];

  // transmit holding register -> serializer stream
  logic             hold_valid;
  logic [REG_W-1:0] hold_data;
  logic             tx_valid, tx_ready, tx_accept;

  assign tx_valid  = hold_valid && !cts_s;
  assign tx_accept = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (mreset) begin
      hold_valid <= 1'b0;
    end else if (!hold_valid) begin
      if (data_wr) begin
        hold_valid <= 1'b1;
        hold_data  <= din;
      end
    end else if (tx_accept) begin
      hold_valid <= 1'b0;
    end
  end

  acia_tx #(.W(REG_W), .OVS(OVS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (mreset),
    .tick_en  (clk_en16),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (hold_data),
    .txd      (txd)
  );

  // receive path
  logic             rx_valid;
  logic [REG_W-1:0] rx_data;
  logic [REG_W-1:0] fifo_head;
  logic             fifo_empty, fifo_full, fifo_afull;

  acia_rx #(.W(REG_W), .OVS(OVS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mreset),
    .tick_en   (clk_en16),
    .rxd       (rxd),
    .out_valid (rx_valid),
    .out_data  (rx_data)
  );

  acia_fifo #(.W(REG_W), .DEPTH(FIFO_DEPTH), .AFULL_LEVEL(AFULL_LEVEL)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mreset),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (data_rd),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .afull     (fifo_afull)
  );

  // status and host read mux
  logic             rx_full, tx_empty, irq;
  logic [REG_W-1:0] status;

  assign rx_full  = !fifo_empty;
  assign tx_empty = !hold_valid;
  assign irq      = (rx_full && rx_ie) || (tx_empty && (txc == TXC_IRQ_ON));

  always_comb begin
    status             = '0;
    status[ST_RXFULL]  = rx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_IRQ]     = irq;
  end

  assign dout  = reg_sel ? fifo_head : status;
  assign rts_n = (txc == TXC_HOLD) || fifo_afull;

  a_r3_write_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_empty && !mreset) |=> !tx_empty);
  a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !tx_empty) |=> $stable(hold_data));
  a_r5_start_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> !$past(cts_s));
  a_r10_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (tx_empty && !rx_full && tx_ready && txd));
  a_r2_one_pop_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> !data_rd);
endmodule

// File: tb/acia_uart_tb.sv
`timescale 1ns/1ps
module acia_uart_tb;
  localparam int EN_DIV   = 4;
  localparam int BIT_CLKS = 16 * EN_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       clk_en16 = 1'b0;
  logic       rxd = 1'b1, cts_n = 1'b0;
  logic       txd, rts_n;
  logic       en_run = 1'b1;
  int         en_cnt = 0;
  int         checks = 0, errors = 0;
  logic [7:0] q [$];

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (en_run && en_cnt == EN_DIV - 1) begin
      en_cnt   <= 0;
      clk_en16 <= 1'b1;
    end else begin
      if (en_run) en_cnt <= en_cnt + 1;
      clk_en16 <= 1'b0;
    end
  end

  acia_uart u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .clk_en16(clk_en16), .rxd(rxd), .txd(txd),
    .rts_n(rts_n), .cts_n(cts_n)
  );

  function automatic logic [7:0] exp_status(input logic rf, input logic te, input logic irq);
    return {irq, 3'b000, 2'b00, te, rf};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic host_rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; rd_n = 1'b0;
    #1 d = dout;
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic line_send(input logic [7:0] d, input logic good_stop);
    rxd = 1'b0; wait_clks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; wait_clks(BIT_CLKS);
    end
    if (good_stop) begin
      rxd = 1'b1; wait_clks(BIT_CLKS);
    end else begin
      rxd = 1'b0; wait_clks(BIT_CLKS / 2 + 8);
      rxd = 1'b1; wait_clks(BIT_CLKS);
    end
  endtask

  task automatic line_capture(output logic [7:0] d, output logic ok);
    int t = 0;
    ok = 1'b0; d = '0;
    while (txd === 1'b1 && t < 4000) begin
      @(negedge clk); t++;
    end
    if (txd !== 1'b0) return;
    wait_clks(BIT_CLKS / 2);
    ok = (txd === 1'b0);
    for (int i = 0; i < 8; i++) begin
      wait_clks(BIT_CLKS);
      d[i] = txd;
    end
    wait_clks(BIT_CLKS);
    ok = ok && (txd === 1'b1);
    wait_clks(BIT_CLKS / 2 + 8);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (R1..R11 incomplete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v, b;
    logic       ok;
    void'($urandom(32'h5eed_0ac1));

    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(3);
    // R1 reset state
    host_rd(0, v);
    chk("R1 status", v, exp_status(0, 1, 0));
    chk("R1 txd", txd, 1);
    chk("R1 rts_n", rts_n, 0);

    // R3 random transmit frames
    for (int k = 0; k < 6; k++) begin
      b = 8'($urandom);
      host_wr(1, b);
      line_capture(v, ok);
      chk("R3 frame ok", ok, 1);
      chk("R3 tx byte", v, b);
    end
    host_rd(0, v);
    chk("R3 tdre back", v, exp_status(0, 1, 0));

    // R5 CTS gating, R4 ignored write
    cts_n = 1'b1;
    wait_clks(10);
    host_wr(1, 8'hA5);
    wait_clks(300);
    chk("R5 txd held idle", txd, 1);
    host_rd(0, v);
    chk("R5 tdre low", v, exp_status(0, 0, 0));
    host_wr(1, 8'h3C);
    cts_n = 1'b0;
    line_capture(v, ok);
    chk("R4 held byte sent", v, 8'hA5);
    wait_clks(700);
    chk("R4 second byte dropped", txd, 1);

    // R6 R7 random receive
    for (int k = 0; k < 5; k++) begin
      b = 8'($urandom);
      q.push_back(b);
      line_send(b, 1'b1);
    end
    host_rd(0, v);
    chk("R2 status rx full", v, exp_status(1, 1, 0));
    for (int k = 0; k < 5; k++) begin
      host_rd(1, v);
      chk("R7 fifo order", v, q.pop_front());
    end
    host_rd(0, v);
    chk("R7 drained", v, exp_status(0, 1, 0));
    host_rd(1, v);
    host_rd(0, v);
    chk("R7 empty read harmless", v, exp_status(0, 1, 0));

    // R6 bad stop and glitch
    line_send(8'h5A, 1'b0);
    wait_clks(300);
    host_rd(0, v);
    chk("R6 bad stop discarded", v, exp_status(0, 1, 0));
    rxd = 1'b0; wait_clks(3 * EN_DIV);
    rxd = 1'b1; wait_clks(2000);
    host_rd(0, v);
    chk("R6 glitch discarded", v, exp_status(0, 1, 0));

    // R8 threshold, R7 overflow
    for (int k = 0; k < 17; k++) begin
      b = 8'($urandom);
      if (k < 16) q.push_back(b);
      line_send(b, 1'b1);
      if (k == 12) chk("R8 rts low at 13", rts_n, 0);
      if (k == 13) chk("R8 rts high at 14", rts_n, 1);
    end
    for (int k = 0; k < 16; k++) begin
      host_rd(1, v);
      chk("R7 full order", v, q.pop_front());
      if (k == 2) chk("R8 rts low below 14", rts_n, 0);
    end
    host_rd(0, v);
    chk("R7 17th dropped", v, exp_status(0, 1, 0));

    // R8 transmitter-control hold
    host_wr(0, 8'h40);
    wait_clks(1);
    chk("R8 tc=10 rts", rts_n, 1);
    host_wr(0, 8'h00);
    wait_clks(1);
    chk("R8 tc=00 rts", rts_n, 0);

    // R9 interrupt
    host_wr(0, 8'h20);
    host_rd(0, v);
    chk("R9 tx irq", v, exp_status(0, 1, 1));
    host_wr(0, 8'h80);
    host_rd(0, v);
    chk("R9 rx ie no data", v, exp_status(0, 1, 0));
    line_send(8'h81, 1'b1);
    host_rd(0, v);
    chk("R9 rx irq", v, exp_status(1, 1, 1));
    host_wr(0, 8'h00);
    host_rd(0, v);
    chk("R9 irq masked", v, exp_status(1, 1, 0));
    host_rd(1, v);
    chk("R9 rx byte", v, 8'h81);

    // R10 master reset
    line_send(8'h11, 1'b1);
    line_send(8'h22, 1'b1);
    cts_n = 1'b1;
    wait_clks(5);
    host_wr(1, 8'h77);
    host_wr(0, 8'hE3);
    host_rd(0, v);
    chk("R10 flags cleared", v, exp_status(0, 1, 0));
    chk("R10 rts", rts_n, 0);
    host_wr(0, 8'h03);
    cts_n = 1'b0;
    wait_clks(1000);
    chk("R10 held byte dropped", txd, 1);
    host_wr(1, 8'hF0);
    wait_clks(100);
    chk("R10 frame running", txd, 0);
    host_wr(0, 8'h03);
    wait_clks(1);
    chk("R10 frame aborted", txd, 1);

    // R11 enable stopped
    en_run = 1'b0;
    wait_clks(4);
    host_wr(1, 8'h55);
    wait_clks(1000);
    chk("R11 frozen start bit", txd, 0);
    en_run = 1'b1;
    wait_clks(700);
    chk("R11 frame resumed and ended", txd, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule